// File: doc/BRIEF.md
# TDM Slot Data Serializer

This block carries audio words between a parallel stream and a single serial data line that is split into time slots. On the transmit side it takes one word per slot through a ready/valid input and shifts the slot out one bit at a time. On the receive side it assembles the bits it captures in a slot into one parallel word. A separate frame generator drives the timing. It supplies a transmit strobe at each bit-clock falling edge, a sample strobe at each bit-clock rising edge, and a marker that flags the first bit of every slot.

The slot length (1 to 32 bits) and the word length are set independently. When the slot is longer than the word, the spare slot bits are padded according to an extension mode. When the slot is shorter, the surplus word bits are dropped on transmit and rebuilt by the same extension mode on receive. The word can sit at the high end or the low end of the slot, and the slot can be sent most significant bit first or least significant bit first. All settings are captured when a slot starts and hold for that whole slot.

Top module: `tdm_slot_serializer`

## Requirements
- R1: `wordCode` selects the word length: 0=8, 1=16, 2=18, 3=20, 4=24, and 5, 6 and 7 all select 32 bits.
- R2: With `rightAdj`=0 and a slot of S bits at least as long as a word of W bits, word bits occupy slot bits S-1..S-W (slot viewed as an S-bit number). The lower S-W bits take the fill value set by `extSel`: 0 gives zeros, 1 gives ones, 2 repeats word bit W-1, and 3 repeats word bit 0.
- R3: With `rightAdj`=1 and S >= W, word bits occupy slot bits W-1..0, and slot bits S-1..W take the fill value from R2.
- R4: With S < W, only S word bits are transmitted. `rightAdj`=0 keeps word bits W-1..W-S, and `rightAdj`=1 keeps word bits S-1..0.
- R5: With `lsbFirst`=0, slot bit S-1 goes out first. With `lsbFirst`=1, slot bit 0 goes out first.
- R6: `txd` changes only at the clock edge of a cycle with `fallTick`=1. `rxd` is captured only on the first `riseTick` cycle after each `fallTick`, so values present in other cycles are ignored.
- R7: `txReady` equals `fallTick & slotStart`. `txWord` is taken only in a cycle with `txValid & txReady`, and its first slot bit appears on `txd` after that edge.
- R8: If `txValid`=0 at the start of a slot, the whole slot is sent as zeros whatever `extSel` says. `txUnderrun` is then high for exactly the one cycle after that start.
- R9: One cycle after the edge that samples a slot's last bit, `rxValid` pulses for one cycle. `rxWord` then holds the word right-justified, and bits 31..W take the fill value from R2, where the MSB/LSB modes use the highest and lowest received word bits.
- R10: With S < W on receive, the word bits not present in the slot (the low W-S bits when `rightAdj`=0, the high W-S bits when `rightAdj`=1) take the fill value.
- R11: `slotLen`, `wordCode`, `rightAdj`, `lsbFirst` and `extSel` are captured at slot start. Changes made during a slot do not affect that slot's transmit bits or its received word.
- R12: After reset, `txd`, `txUnderrun` and `rxValid` are 0. No word is received before the first slot start.
- R13: Transmit strobes after bit S-1 of a slot drive `txd`=0, and samples after the last slot bit are ignored. `slotLen`=0 is treated as 1, and values above 32 are treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fallTick | input | 1 | Bit-clock falling-edge strobe (transmit advance) |
| riseTick | input | 1 | Bit-clock rising-edge strobe (receive sample) |
| slotStart | input | 1 | Marks the fallTick of a slot's first bit |
| slotLen | input | 6 | Slot length in bits, 1 to 32 |
| wordCode | input | 3 | Word length code |
| rightAdj | input | 1 | 1 places the word at the low end of the slot |
| lsbFirst | input | 1 | 1 sends slot bit 0 first |
| extSel | input | 2 | Fill mode: zeros, ones, repeat MSB, repeat LSB |
| txWord | input | 32 | Transmit word, right-justified |
| txValid | input | 1 | Transmit word available |
| txReady | output | 1 | Word accepted this cycle if valid |
| txd | output | 1 | Serial transmit data |
| txUnderrun | output | 1 | Pulse: slot started without a word |
| rxd | input | 1 | Serial receive data |
| rxWord | output | 32 | Received word, right-justified and extended |
| rxValid | output | 1 | Pulse: rxWord is new |

## Verification
Two things land on the same clock edge: a slot's received word is completed, and the next slot's transmit word is loaded along with new settings. The bench provokes this by issuing the next slot-start strobe in the cycle right after the last sample strobe. Most randomly drawn slots also carry different settings from the slot before. Each received word is compared against a value computed from the settings of the slot it belongs to, while the first transmitted bit is compared against the new slot's settings. This shows the word completion reads the captured settings rather than the ones arriving in the same cycle.

// File: rtl/tdm_ser_pkg.sv
`timescale 1ns/1ps
package tdm_ser_pkg;
  localparam int MAX_BITS = 32;
  localparam int POS_W = $clog2(MAX_BITS) + 1;
  localparam int IDX_W = $clog2(MAX_BITS);

  typedef enum logic [1:0] {
    EXT_ZERO = 2'd0,
    EXT_ONE  = 2'd1,
    EXT_MSB  = 2'd2,
    EXT_LSB  = 2'd3
  } ext_e;

  typedef struct packed {
    logic [POS_W-1:0] slotLen;
    logic [POS_W-1:0] wordLen;
    logic             rightAdj;
    logic             lsbFirst;
    ext_e             ext;
  } slot_cfg_t;

  typedef struct packed {
    logic             load;
    logic             shift;
    logic             idle;
    logic             sample;
    logic             lastSample;
    logic [POS_W-1:0] txPos;
    logic [POS_W-1:0] rxPos;
  } ser_strobe_t;

  function automatic logic [POS_W-1:0] decodeWordLen(input logic [2:0] code);
    case (code)
      3'd0:    return POS_W'(8);
      3'd1:    return POS_W'(16);
      3'd2:    return POS_W'(18);
      3'd3:    return POS_W'(20);
      3'd4:    return POS_W'(24);
      default: return POS_W'(MAX_BITS);
    endcase
  endfunction

  function automatic logic [POS_W-1:0] clampSlotLen(input logic [POS_W-1:0] raw);
    if (raw == '0) return POS_W'(1);
    if (int'(raw) > MAX_BITS) return POS_W'(MAX_BITS);
    return raw;
  endfunction

  // Map a time position within the slot to a slot bit index
  function automatic logic [IDX_W-1:0] slotIndex(input logic [POS_W-1:0] pos,
                                                  input slot_cfg_t cfg);
    logic [POS_W-1:0] idx;
    idx = cfg.lsbFirst ? pos : (cfg.slotLen - POS_W'(1) - pos);
    return idx[IDX_W-1:0];
  endfunction

  function automatic logic fillBit(input ext_e ext, input logic msb, input logic lsb);
    case (ext)
      EXT_ZERO: return 1'b0;
      EXT_ONE:  return 1'b1;
      EXT_MSB:  return msb;
      default:  return lsb;
    endcase
  endfunction

  function automatic logic [MAX_BITS-1:0] buildSlot(input logic [MAX_BITS-1:0] word,
                                                     input slot_cfg_t cfg);
    int s, w, wi;
    logic f;
    logic [MAX_BITS-1:0] img;
    s = int'(cfg.slotLen);
    w = int'(cfg.wordLen);
    f = fillBit(cfg.ext, word[IDX_W'(w - 1)], word[0]);
    img = '0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < s) begin
        wi = cfg.rightAdj ? i : i + w - s;
        if (wi >= 0 && wi < w) img[i] = word[IDX_W'(wi)];
        else                   img[i] = f;
      end
    end
    return img;
  endfunction

  function automatic logic [MAX_BITS-1:0] extractWord(input logic [MAX_BITS-1:0] slot,
                                                       input slot_cfg_t cfg);
    int s, w, si, n;
    logic msb, lsb, f;
    logic [MAX_BITS-1:0] wd;
    s = int'(cfg.slotLen);
    w = int'(cfg.wordLen);
    n = (w < s) ? w : s;
    msb = cfg.rightAdj ? slot[IDX_W'(n - 1)] : slot[IDX_W'(s - 1)];
    lsb = cfg.rightAdj ? slot[0] : slot[IDX_W'((s > w) ? (s - w) : 0)];
    f = fillBit(cfg.ext, msb, lsb);
    for (int k = 0; k < MAX_BITS; k++) begin
      wd[k] = f;
      if (k < w) begin
        si = cfg.rightAdj ? k : k + s - w;
        if (si >= 0 && si < s) wd[k] = slot[IDX_W'(si)];
      end
    end
    return wd;
  endfunction
endpackage

// File: rtl/tdm_ser_ctrl.sv
`timescale 1ns/1ps
module tdm_ser_ctrl
  import tdm_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fallTick,
  input  logic             riseTick,
  input  logic             slotStart,
  input  logic [POS_W-1:0] slotLenIn,
  input  logic [2:0]       wordCode,
  input  logic             rightAdj,
  input  logic             lsbFirst,
  input  logic [1:0]       extSel,
  output slot_cfg_t        cfgLive,
  output slot_cfg_t        cfgSlot,
  output ser_strobe_t      st
);
  logic [POS_W-1:0] bitIdx;
  logic [POS_W-1:0] nextIdx;
  logic             active;
  logic             sampled;

  always_comb begin
    cfgLive.slotLen  = clampSlotLen(slotLenIn);
    cfgLive.wordLen  = decodeWordLen(wordCode);
    cfgLive.rightAdj = rightAdj;
    cfgLive.lsbFirst = lsbFirst;
    cfgLive.ext      = ext_e'(extSel);
  end

  assign nextIdx = bitIdx + POS_W'(1);

  always_comb begin
    st.load       = fallTick & slotStart;
    st.shift      = fallTick & ~slotStart & active & (nextIdx < cfgSlot.slotLen);
    st.idle       = fallTick & ~slotStart & ~st.shift;
    st.txPos      = slotStart ? '0 : nextIdx;
    st.sample     = riseTick & ~fallTick & active & ~sampled & (bitIdx < cfgSlot.slotLen);
    st.lastSample = st.sample & (bitIdx == cfgSlot.slotLen - POS_W'(1));
    st.rxPos      = bitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx  <= '0;
      active  <= 1'b0;
      sampled <= 1'b0;
      cfgSlot <= '{slotLen: POS_W'(MAX_BITS), wordLen: POS_W'(MAX_BITS),
                   rightAdj: 1'b0, lsbFirst: 1'b0, ext: EXT_ZERO};
    end else begin
      if (fallTick)       sampled <= 1'b0;
      else if (st.sample) sampled <= 1'b1;
      if (fallTick && slotStart) begin
        bitIdx  <= '0;
        active  <= 1'b1;
        cfgSlot <= cfgLive;
      end else if (fallTick && active && bitIdx < POS_W'(MAX_BITS)) begin
        bitIdx <= nextIdx;
      end
    end
  end

  // R6
  one_sample_per_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.sample |=> !st.sample);
endmodule

// File: rtl/tdm_ser_datapath.sv
`timescale 1ns/1ps
module tdm_ser_datapath
  import tdm_ser_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ser_strobe_t         st,
  input  slot_cfg_t           cfgLive,
  input  slot_cfg_t           cfgSlot,
  input  logic [MAX_BITS-1:0] txWord,
  input  logic                txValid,
  input  logic                rxd,
  output logic                txd,
  output logic                txUnderrun,
  output logic [MAX_BITS-1:0] rxWord,
  output logic                rxValid
);
  logic [MAX_BITS-1:0] txImage;
  logic [MAX_BITS-1:0] loadImage;
  logic [MAX_BITS-1:0] rxSlot;
  logic                rxPending;

  assign loadImage = txValid ? buildSlot(txWord, cfgLive) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txImage    <= '0;
      txd        <= 1'b0;
      txUnderrun <= 1'b0;
    end else if (st.load) begin
      txImage    <= loadImage;
      txd        <= loadImage[slotIndex(POS_W'(0), cfgLive)];
      txUnderrun <= ~txValid;
    end else begin
      txUnderrun <= 1'b0;
      if (st.shift)     txd <= txImage[slotIndex(st.txPos, cfgSlot)];
      else if (st.idle) txd <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSlot    <= '0;
      rxPending <= 1'b0;
      rxWord    <= '0;
      rxValid   <= 1'b0;
    end else begin
      if (st.sample) rxSlot[slotIndex(st.rxPos, cfgSlot)] <= rxd;
      rxPending <= st.lastSample;
      rxValid   <= rxPending;
      if (rxPending) rxWord <= extractWord(rxSlot, cfgSlot);
    end
  end

  // R8
  underrun_zero_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.load && !txValid) |=> (txUnderrun && !txd));

  // R9
  rx_valid_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(st.lastSample, 2));
endmodule

// File: rtl/tdm_slot_serializer.sv
`timescale 1ns/1ps
module tdm_slot_serializer
  import tdm_ser_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                fallTick,
  input  logic                riseTick,
  input  logic                slotStart,
  input  logic [POS_W-1:0]    slotLen,
  input  logic [2:0]          wordCode,
  input  logic                rightAdj,
  input  logic                lsbFirst,
  input  logic [1:0]          extSel,
  input  logic [MAX_BITS-1:0] txWord,
  input  logic                txValid,
  output logic                txReady,
  output logic                txd,
  output logic                txUnderrun,
  input  logic                rxd,
  output logic [MAX_BITS-1:0] rxWord,
  output logic                rxValid
);
  slot_cfg_t   cfgLive;
  slot_cfg_t   cfgSlot;
  ser_strobe_t st;

  assign txReady = st.load;

  tdm_ser_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fallTick(fallTick), .riseTick(riseTick),
    .slotStart(slotStart), .slotLenIn(slotLen), .wordCode(wordCode),
    .rightAdj(rightAdj), .lsbFirst(lsbFirst), .extSel(extSel),
    .cfgLive(cfgLive), .cfgSlot(cfgSlot), .st(st)
  );

  tdm_ser_datapath uData (
    .clk(clk), .rstN(rstN), .st(st), .cfgLive(cfgLive), .cfgSlot(cfgSlot),
    .txWord(txWord), .txValid(txValid), .rxd(rxd), .txd(txd),
    .txUnderrun(txUnderrun), .rxWord(rxWord), .rxValid(rxValid)
  );

  // R6
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fallTick |=> $stable(txd));
endmodule

// File: tb/tb_tdm_slot_serializer.sv
`timescale 1ns/1ps
module tb_tdm_slot_serializer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fallTick = 1'b0, riseTick = 1'b0, slotStart = 1'b0;
  logic [5:0]  slotLen = 6'd32;
  logic [2:0]  wordCode = 3'd0;
  logic        rightAdj = 1'b0, lsbFirst = 1'b0;
  logic [1:0]  extSel = 2'd0;
  logic [31:0] txWord = '0;
  logic        txValid = 1'b0;
  logic        txReady, txd, txUnderrun;
  logic        rxd = 1'b0;
  logic [31:0] rxWord;
  logic        rxValid;

  int checks = 0, fails = 0;
  bit pend = 0;
  logic [31:0] pendWord;
  string pendTag;
  bit finished = 0;

  tdm_slot_serializer dut (
    .clk(clk), .rstN(rstN), .fallTick(fallTick), .riseTick(riseTick),
    .slotStart(slotStart), .slotLen(slotLen), .wordCode(wordCode),
    .rightAdj(rightAdj), .lsbFirst(lsbFirst), .extSel(extSel),
    .txWord(txWord), .txValid(txValid), .txReady(txReady), .txd(txd),
    .txUnderrun(txUnderrun), .rxd(rxd), .rxWord(rxWord), .rxValid(rxValid)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wlen(input logic [2:0] code);
    case (code)
      3'd0: return 8;
      3'd1: return 16;
      3'd2: return 18;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] m32(input int n);
    logic [63:0] t;
    t = (64'd1 << n) - 64'd1;
    return t[31:0];
  endfunction

  function automatic logic [31:0] expSlot(input logic [31:0] word, input bit valid,
      input int s, input int w, input bit right, input logic [1:0] ext);
    logic f;
    logic [31:0] wm, v;
    if (!valid) return 32'd0;
    f = (ext == 2'd0) ? 1'b0 : (ext == 2'd1) ? 1'b1 : (ext == 2'd2) ? word[w-1] : word[0];
    wm = word & m32(w);
    if (right) v = (s <= w) ? (wm & m32(s)) : (wm | (f ? (m32(s) & ~m32(w)) : 32'd0));
    else       v = (s >= w) ? ((wm << (s - w)) | (f ? m32(s - w) : 32'd0)) : (wm >> (w - s));
    return v;
  endfunction

  function automatic logic [31:0] expRx(input logic [31:0] sv, input int s, input int w,
      input bit right, input logic [1:0] ext);
    int n;
    logic [31:0] got, known;
    logic msb, lsb, f;
    n = (s < w) ? s : w;
    if (right) begin
      got = sv & m32(n); known = m32(n); msb = sv[n-1]; lsb = sv[0];
    end else if (s >= w) begin
      got = (sv >> (s - w)) & m32(w); known = m32(w); msb = sv[s-1]; lsb = sv[s-w];
    end else begin
      got = (sv & m32(s)) << (w - s); known = m32(w) & ~m32(w - s);
      msb = sv[s-1]; lsb = sv[0];
    end
    f = (ext == 2'd0) ? 1'b0 : (ext == 2'd1) ? 1'b1 : (ext == 2'd2) ? msb : lsb;
    return got | (f ? ~known : 32'd0);
  endfunction

  task automatic rxCheck();
    if (pend) begin
      chk(rxValid === 1'b1, {pendTag, " rxValid"}, {31'd0, rxValid}, 32'd1);
      chk(rxWord === pendWord, {pendTag, " rxWord"}, rxWord, pendWord);
      pend = 0;
    end else begin
      chk(rxValid === 1'b0, "R9 no spurious rxValid", {31'd0, rxValid}, 32'd0);
    end
  endtask

  // one slot of s bits plus 'extra' strobes past its end
  task automatic runSlot(input int s, input logic [2:0] code, input bit right,
      input bit lsb, input logic [1:0] ext, input logic [31:0] word, input bit valid,
      input logic [31:0] rxSv, input int extra, input string tag);
    int w;
    logic [31:0] sv;
    logic eb, lastEb;
    string txTag;
    w = wlen(code);
    sv = expSlot(word, valid, s, w, right, ext);
    txTag = (s < w) ? "R4" : (right ? "R3" : "R2");
    lastEb = 1'b0;
    for (int p = 0; p < s + extra; p++) begin
      @(negedge clk);
      if (p > 0) chk(txd === lastEb, "R6 txd held between strobes", {31'd0, txd}, {31'd0, lastEb});
      riseTick = 1'b0; rxd = ~rxd; fallTick = 1'b1; slotStart = (p == 0);
      if (p == 0) begin
        slotLen = 6'(s); wordCode = code; rightAdj = right; lsbFirst = lsb;
        extSel = ext; txWord = word; txValid = valid;
      end
      #1;
      chk(txReady === (p == 0), "R7 txReady", {31'd0, txReady}, {31'd0, (p == 0)});
      @(negedge clk);
      fallTick = 1'b0; slotStart = 1'b0;
      txValid = 1'($urandom); txWord = $urandom;
      if (p == 0) begin
        slotLen = 6'($urandom); wordCode = 3'($urandom); rightAdj = 1'($urandom);
        lsbFirst = 1'($urandom); extSel = 2'($urandom);
      end
      #1;
      eb = (p < s) ? (lsb ? sv[p] : sv[s-1-p]) : 1'b0;
      if (p < s) chk(txd === eb, $sformatf("%s %s R5 bit %0d", tag, txTag, p), {31'd0, txd}, {31'd0, eb});
      else       chk(txd === 1'b0, "R13 txd after slot end", {31'd0, txd}, 32'd0);
      if (p == 0) chk(txUnderrun === !valid, "R8 txUnderrun", {31'd0, txUnderrun}, {31'd0, !valid});
      else        chk(txUnderrun === 1'b0, "R8 underrun pulse length", {31'd0, txUnderrun}, 32'd0);
      rxCheck();
      rxd = (p < s) ? (lsb ? rxSv[p] : rxSv[s-1-p]) : 1'($urandom);
      riseTick = 1'b1;
      lastEb = eb;
      if (p == s - 1) begin
        pend = 1;
        pendWord = expRx(rxSv, s, w, right, ext);
        pendTag = {tag, (s < w) ? " R10" : " R9"};
      end
    end
  endtask

  task automatic flush();
    @(negedge clk);
    riseTick = 1'b0; fallTick = 1'b0; rxd = ~rxd;
    @(negedge clk);
    #1;
    rxCheck();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    // R12 reset state
    chk(txd === 1'b0, "R12 txd reset", {31'd0, txd}, 32'd0);
    chk(rxValid === 1'b0, "R12 rxValid reset", {31'd0, rxValid}, 32'd0);
    chk(txUnderrun === 1'b0, "R12 txUnderrun reset", {31'd0, txUnderrun}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    // R12 strobes before the first slot start do nothing
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      fallTick = (i % 2 == 0); riseTick = (i % 2 == 1); rxd = 1'b1;
      #1;
      chk(rxValid === 1'b0 && txd === 1'b0, "R12 idle before first slot",
          {30'd0, rxValid, txd}, 32'd0);
    end
    @(negedge clk);
    fallTick = 1'b0; riseTick = 1'b0;

    // R1 every word size code, left placement, zero fill, full slot
    for (int c = 0; c < 8; c++)
      runSlot(32, 3'(c), 1'b0, 1'b0, 2'd0, 32'hA5C3_96E1, 1'b1, 32'h3C5A_F00F, 0, "R1");
    // R2 each fill mode with a long slot
    for (int e = 0; e < 4; e++) begin
      runSlot(32, 3'd0, 1'b0, 1'b0, 2'(e), 32'h0000_0081, 1'b1, 32'h8100_0000, 0, "R2");
      runSlot(32, 3'd0, 1'b0, 1'b0, 2'(e), 32'h0000_007E, 1'b1, 32'h7E00_0001, 0, "R2");
    end
    // R3 right placement, each fill mode
    for (int e = 0; e < 4; e++)
      runSlot(24, 3'd1, 1'b1, 1'b1, 2'(e), 32'h0000_8001, 1'b1, 32'h00FF_8001, 0, "R3");
    // R4 R10 slot shorter than the word, both placements
    for (int e = 0; e < 4; e++) begin
      runSlot(16, 3'd4, 1'b0, 1'b0, 2'(e), 32'h00C0_0FF3, 1'b1, 32'h0000_C00F, 0, "R4");
      runSlot(8,  3'd5, 1'b1, 1'b1, 2'(e), 32'h8000_0081, 1'b1, 32'h0000_0081, 0, "R4");
    end
    // R8 underrun with ones fill selected
    runSlot(16, 3'd1, 1'b0, 1'b0, 2'd1, 32'hFFFF_FFFF, 1'b0, 32'h0000_FFFF, 0, "R8");
    // R13 extra strobes past slot end, and one-bit slot
    runSlot(8, 3'd0, 1'b1, 1'b0, 2'd2, 32'h0000_00F0, 1'b1, 32'h0000_00AA, 3, "R13");
    runSlot(1, 3'd0, 1'b0, 1'b1, 2'd2, 32'h0000_0080, 1'b1, 32'h0000_0001, 0, "R13");
    flush();

    // R11 random settings, scrambled mid-slot, back-to-back slots
    for (int n = 0; n < 250; n++) begin
      runSlot(1 + int'($urandom % 32), 3'($urandom), 1'($urandom), 1'($urandom),
              2'($urandom), $urandom, ($urandom % 10) != 0, $urandom,
              (($urandom % 8) == 0) ? 2 : 0, "R11");
    end
    flush();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule